// File: doc/BRIEF.md
# Receive Descriptor Ring Controller

This block moves received frame or cell payloads into memory buffers described by a circular table of receive descriptors. The descriptors sit in a small on-chip descriptor memory that software fills through a simple word port. When the first byte of a frame arrives, the controller reads the current descriptor. If the controller owns that descriptor, it streams each payload byte out to the buffer address held in the descriptor. At the end of the frame it writes the byte count into the length word and then the updated status word, and steps to the next descriptor.

The ring has no length register. Its size is fixed by the descriptor that carries the wrap flag: after that descriptor is closed, the controller goes back to the programmed base slot. Running past the last slot that the descriptor memory can hold (never more than 64 KB of table space) without meeting a wrap flag raises a table error, and the controller also returns to the base slot.

Descriptors with the interrupt flag post a buffer event when they close. The events are counted against a programmable threshold, and a global flag is set when the count reaches it. Software writes 1 to the acknowledge input to clear both the flag and the count.

A descriptor is eight bytes, stored as four 16-bit words: word 0 is status, word 1 is length, word 2 is the pointer high half and word 3 is the pointer low half. Status bits are counted from the MSB. Bit 0 (value 0x8000) is Empty, bit 2 (0x2000) is Wrap, bit 3 (0x1000) is Interrupt, bit 4 (0x0800) is Sequence error and bit 6 (0x0200) is Continuous. All other status bits are reserved.

The control FSM has five states:
- IDLE waits for a first byte and checks ownership.
- RECV streams the remaining bytes.
- DROP swallows a frame that found its descriptor not owned.
- WR_LEN writes the length word.
- WR_STAT writes the status word, posts the event and advances the pointer.

The transitions are:
- IDLE→RECV on an owned first byte.
- IDLE→WR_LEN on an owned single-byte frame.
- IDLE→DROP on an unowned first byte that is not the last byte.
- DROP→IDLE on the last byte.
- RECV→WR_LEN on the last byte.
- WR_LEN→WR_STAT always.
- WR_STAT→IDLE always.

Frames must be separated by at least two idle cycles so that the close can finish.

Top module: `rxbd_ring_ctrl`

## Requirements
- R1: After reset, the ring pointer `cur_idx` equals `cfg_base`, `gint` is 0, `evt_count` is 0 and no buffer write is issued.
- R2: For a frame that finds an owned descriptor (Empty=1), byte k of the frame is written to buffer address pointer+k, one byte per valid cycle, starting in the cycle of the first byte.
- R3: On close, word 1 of the descriptor is written with the frame's byte count, and this happens in the cycle before word 0 (status) is written.
- R4: The closing status keeps Wrap (0x2000), Interrupt (0x1000) and Continuous (0x0200) and clears Empty (0x8000) when Continuous is 0. It sets Sequence error (0x0800) only if `rx_seq_err` was high with the last byte. All reserved bits are written as 0.
- R5: After a descriptor without Wrap is closed, the pointer moves to the next slot. After a descriptor with Wrap is closed, the pointer returns to `cfg_base`.
- R6: A frame whose first byte finds Empty=0 is dropped. `rx_busy` pulses exactly once, no buffer write occurs, the pointer does not move and the descriptor stays unchanged.
- R7: With Continuous=1, Empty stays 1 after close, so the next frame that reaches the same descriptor overwrites the same buffer from its start.
- R8: `buf_evt` pulses once when a descriptor with Interrupt=1 closes, and never for a descriptor with Interrupt=0.
- R9: Each buffer event increments `evt_count`. `gint` is set once the count reaches `cfg_thresh`, stays 0 below it, and then holds until it is acknowledged.
- R10: A cycle with `gint_ack`=1 clears both `gint` and `evt_count`.
- R11: Closing the last slot of the descriptor memory without Wrap pulses `table_err` and returns the pointer to `cfg_base`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; also clears the descriptor memory |
| cfg_base | input | IW | Slot index of the first descriptor in the ring |
| cfg_thresh | input | CW | Event count at which `gint` is set |
| gint_ack | input | 1 | Write 1 to clear `gint` and `evt_count` |
| sw_we | input | 1 | Software write strobe to descriptor memory |
| sw_addr | input | AW | Software word address (slot*4 + word) |
| sw_wdata | input | 16 | Software write data |
| sw_rdata | output | 16 | Descriptor memory word at `sw_addr` |
| rx_valid | input | 1 | A payload byte is present |
| rx_data | input | 8 | Payload byte |
| rx_last | input | 1 | Last byte of the frame |
| rx_seq_err | input | 1 | Sequence error flag, sampled with the last byte |
| buf_wr_en | output | 1 | Buffer byte write strobe |
| buf_wr_addr | output | 32 | Buffer byte address |
| buf_wr_data | output | 8 | Buffer byte data |
| rx_busy | output | 1 | Pulse: the frame was dropped because the descriptor is not owned |
| buf_evt | output | 1 | Pulse: a buffer event was posted |
| table_err | output | 1 | Pulse: the table end was reached without Wrap |
| gint | output | 1 | Global interrupt flag |
| evt_count | output | CW | Buffer event count |
| cur_idx | output | IW | Current ring slot |

## Verification
The main function is exercised with four kinds of frame:
- Multi-byte frames with and without a sequence error, into a two-slot ring. These separate the plain advance from the wrap to base and show that Sequence error tracks the last-byte flag.
- A frame that meets a closed descriptor. This shows that dropping is kept apart from receiving: no writes, the pointer held and the status untouched.
- Two frames of different lengths into a one-slot continuous ring. These show that the same buffer is rewritten and that the length follows the latest frame.
- A single-byte frame into the final memory slot after a reset with a non-zero base. This covers the shortest FSM path, the table error return and the reset pointer.

// File: rtl/rxbd_pkg.sv
package rxbd_pkg;
    // Status bit positions, numbered so that descriptor bit 0 is the MSB
    localparam int unsigned ST_EMPTY = 15;
    localparam int unsigned ST_WRAP  = 13;
    localparam int unsigned ST_INTR  = 12;
    localparam int unsigned ST_SEQE  = 11;
    localparam int unsigned ST_CONT  = 9;

    // Word offsets inside a descriptor
    localparam logic [1:0] W_STAT = 2'd0;
    localparam logic [1:0] W_LEN  = 2'd1;
    localparam logic [1:0] W_PHI  = 2'd2;
    localparam logic [1:0] W_PLO  = 2'd3;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RECV,
        S_DROP,
        S_WR_LEN,
        S_WR_STAT
    } ring_state_t;
endpackage

// File: rtl/rxbd_desc_mem.sv
module rxbd_desc_mem
    import rxbd_pkg::*;
#(
    parameter int NUM_DESC = 8,
    localparam int IW = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1,
    localparam int AW = IW + 2,
    localparam int WORDS = NUM_DESC * 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sw_we,
    input  logic [AW-1:0] sw_addr,
    input  logic [15:0]   sw_wdata,
    output logic [15:0]   sw_rdata,
    input  logic          hw_we,
    input  logic [AW-1:0] hw_addr,
    input  logic [15:0]   hw_wdata,
    input  logic [IW-1:0] rd_idx,
    output logic [15:0]   rd_stat,
    output logic [31:0]   rd_ptr
);
    logic [15:0] mem [WORDS];

    // Controller write-back has priority over software writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= '0;
        end else if (hw_we) begin
            mem[hw_addr] <= hw_wdata;
        end else if (sw_we) begin
            mem[sw_addr] <= sw_wdata;
        end
    end

    assign sw_rdata = mem[sw_addr];
    assign rd_stat  = mem[{rd_idx, W_STAT}];
    assign rd_ptr   = {mem[{rd_idx, W_PHI}], mem[{rd_idx, W_PLO}]};
endmodule

// File: rtl/rxbd_evt_counter.sv
module rxbd_evt_counter #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          evt,
    input  logic          ack,
    input  logic [CW-1:0] thresh,
    output logic [CW-1:0] count,
    output logic          flag
);
    logic [CW-1:0] count_inc;

    assign count_inc = (count == {CW{1'b1}}) ? count : count + 1'b1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            flag  <= 1'b0;
        end else if (ack) begin
            count <= '0;
            flag  <= 1'b0;
        end else if (evt) begin
            count <= count_inc;
            if (count_inc >= thresh) flag <= 1'b1;
        end
    end

    assert_flag_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !ack) |=> flag);

    assert_ack_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> (count == '0 && !flag));
endmodule

// File: rtl/rxbd_ring_fsm.sv
module rxbd_ring_fsm
    import rxbd_pkg::*;
#(
    parameter int NUM_DESC = 8,
    parameter int LW = 16,
    localparam int IW = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1,
    localparam int AW = IW + 2,
    localparam int TABLE_SLOTS = (NUM_DESC < 8192) ? NUM_DESC : 8192,
    localparam logic [IW-1:0] LAST_IDX = IW'(TABLE_SLOTS - 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] cfg_base,
    input  logic          rx_valid,
    input  logic [7:0]    rx_data,
    input  logic          rx_last,
    input  logic          rx_seq_err,
    input  logic [15:0]   d_stat,
    input  logic [31:0]   d_ptr,
    output logic [IW-1:0] cur_idx,
    output logic          buf_wr_en,
    output logic [31:0]   buf_wr_addr,
    output logic [7:0]    buf_wr_data,
    output logic          rx_busy,
    output logic          hw_we,
    output logic [AW-1:0] hw_addr,
    output logic [15:0]   hw_wdata,
    output logic          buf_evt,
    output logic          table_err
);
    ring_state_t state, state_n;
    logic [15:0]  stat_q;
    logic [31:0]  ptr_q;
    logic [LW-1:0] cnt_q;
    logic          seqe_q;
    logic          owned;
    logic          at_end;
    logic [15:0]   close_stat;

    assign owned  = d_stat[ST_EMPTY];
    assign at_end = (cur_idx == LAST_IDX);

    always_comb begin
        close_stat = '0;
        close_stat[ST_EMPTY] = stat_q[ST_CONT];
        close_stat[ST_WRAP]  = stat_q[ST_WRAP];
        close_stat[ST_INTR]  = stat_q[ST_INTR];
        close_stat[ST_CONT]  = stat_q[ST_CONT];
        close_stat[ST_SEQE]  = seqe_q;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_n;
    end

    // Next state and outputs
    always_comb begin
        state_n     = state;
        buf_wr_en   = 1'b0;
        buf_wr_addr = ptr_q + 32'(cnt_q);
        buf_wr_data = rx_data;
        rx_busy     = 1'b0;
        hw_we       = 1'b0;
        hw_addr     = {cur_idx, W_STAT};
        hw_wdata    = close_stat;
        buf_evt     = 1'b0;
        table_err   = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (rx_valid) begin
                    if (owned) begin
                        buf_wr_en   = 1'b1;
                        buf_wr_addr = d_ptr;
                        state_n     = rx_last ? S_WR_LEN : S_RECV;
                    end else begin
                        rx_busy = 1'b1;
                        state_n = rx_last ? S_IDLE : S_DROP;
                    end
                end
            end
            S_RECV: begin
                if (rx_valid) begin
                    buf_wr_en = 1'b1;
                    if (rx_last) state_n = S_WR_LEN;
                end
            end
            S_DROP: begin
                if (rx_valid && rx_last) state_n = S_IDLE;
            end
            S_WR_LEN: begin
                hw_we    = 1'b1;
                hw_addr  = {cur_idx, W_LEN};
                hw_wdata = 16'(cnt_q);
                state_n  = S_WR_STAT;
            end
            S_WR_STAT: begin
                hw_we     = 1'b1;
                buf_evt   = stat_q[ST_INTR];
                table_err = at_end && !stat_q[ST_WRAP];
                state_n   = S_IDLE;
            end
            default: state_n = S_IDLE;
        endcase
    end

    // Frame datapath and ring pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_idx <= cfg_base;
            stat_q  <= '0;
            ptr_q   <= '0;
            cnt_q   <= '0;
            seqe_q  <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (rx_valid && owned) begin
                        stat_q <= d_stat;
                        ptr_q  <= d_ptr;
                        cnt_q  <= LW'(1);
                        seqe_q <= rx_last && rx_seq_err;
                    end
                end
                S_RECV: begin
                    if (rx_valid) begin
                        cnt_q <= cnt_q + 1'b1;
                        if (rx_last) seqe_q <= rx_seq_err;
                    end
                end
                S_WR_STAT: begin
                    if (stat_q[ST_WRAP] || at_end) cur_idx <= cfg_base;
                    else                           cur_idx <= cur_idx + 1'b1;
                end
                default: ;
            endcase
        end
    end

    assert_len_before_stat_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WR_STAT) |-> ($past(state) == S_WR_LEN));

    assert_busy_holds_ptr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_busy |=> $stable(cur_idx));

    assert_drop_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DROP) |-> !buf_wr_en);

    assert_wrap_to_base_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WR_STAT && stat_q[ST_WRAP]) |=> (cur_idx == $past(cfg_base)));

    assert_table_err_base_R11: assert property (@(posedge clk) disable iff (!rst_n)
        table_err |=> (cur_idx == $past(cfg_base)));

    assert_excl_pulses_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({buf_wr_en, rx_busy, hw_we}));
endmodule

// File: rtl/rxbd_ring_ctrl.sv
module rxbd_ring_ctrl #(
    parameter int NUM_DESC = 8,
    parameter int CW = 8,
    localparam int IW = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1,
    localparam int AW = IW + 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] cfg_base,
    input  logic [CW-1:0] cfg_thresh,
    input  logic          gint_ack,
    input  logic          sw_we,
    input  logic [AW-1:0] sw_addr,
    input  logic [15:0]   sw_wdata,
    output logic [15:0]   sw_rdata,
    input  logic          rx_valid,
    input  logic [7:0]    rx_data,
    input  logic          rx_last,
    input  logic          rx_seq_err,
    output logic          buf_wr_en,
    output logic [31:0]   buf_wr_addr,
    output logic [7:0]    buf_wr_data,
    output logic          rx_busy,
    output logic          buf_evt,
    output logic          table_err,
    output logic          gint,
    output logic [CW-1:0] evt_count,
    output logic [IW-1:0] cur_idx
);
    logic          hw_we;
    logic [AW-1:0] hw_addr;
    logic [15:0]   hw_wdata;
    logic [15:0]   d_stat;
    logic [31:0]   d_ptr;

    rxbd_desc_mem #(.NUM_DESC(NUM_DESC)) u_mem (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_we    (sw_we),
        .sw_addr  (sw_addr),
        .sw_wdata (sw_wdata),
        .sw_rdata (sw_rdata),
        .hw_we    (hw_we),
        .hw_addr  (hw_addr),
        .hw_wdata (hw_wdata),
        .rd_idx   (cur_idx),
        .rd_stat  (d_stat),
        .rd_ptr   (d_ptr)
    );

    rxbd_ring_fsm #(.NUM_DESC(NUM_DESC)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_base    (cfg_base),
        .rx_valid    (rx_valid),
        .rx_data     (rx_data),
        .rx_last     (rx_last),
        .rx_seq_err  (rx_seq_err),
        .d_stat      (d_stat),
        .d_ptr       (d_ptr),
        .cur_idx     (cur_idx),
        .buf_wr_en   (buf_wr_en),
        .buf_wr_addr (buf_wr_addr),
        .buf_wr_data (buf_wr_data),
        .rx_busy     (rx_busy),
        .hw_we       (hw_we),
        .hw_addr     (hw_addr),
        .hw_wdata    (hw_wdata),
        .buf_evt     (buf_evt),
        .table_err   (table_err)
    );

    rxbd_evt_counter #(.CW(CW)) u_evt (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt    (buf_evt),
        .ack    (gint_ack),
        .thresh (cfg_thresh),
        .count  (evt_count),
        .flag   (gint)
    );
endmodule

// File: tb/rxbd_ring_ctrl_bench.sv
module rxbd_ring_ctrl_bench;
    localparam int NUM_DESC = 8;
    localparam int CW = 8;
    localparam int IW = 3;
    localparam int AW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [IW-1:0] cfg_base = '0;
    logic [CW-1:0] cfg_thresh = 8'd2;
    logic gint_ack = 1'b0;
    logic sw_we = 1'b0;
    logic [AW-1:0] sw_addr = '0;
    logic [15:0] sw_wdata = '0;
    logic [15:0] sw_rdata;
    logic rx_valid = 1'b0;
    logic [7:0] rx_data = '0;
    logic rx_last = 1'b0;
    logic rx_seq_err = 1'b0;
    logic buf_wr_en;
    logic [31:0] buf_wr_addr;
    logic [7:0] buf_wr_data;
    logic rx_busy, buf_evt, table_err, gint;
    logic [CW-1:0] evt_count;
    logic [IW-1:0] cur_idx;

    always #2.5 clk = ~clk;

    rxbd_ring_ctrl #(.NUM_DESC(NUM_DESC), .CW(CW)) u_rxbd_ring_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_thresh(cfg_thresh),
        .gint_ack(gint_ack), .sw_we(sw_we), .sw_addr(sw_addr), .sw_wdata(sw_wdata),
        .sw_rdata(sw_rdata), .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last),
        .rx_seq_err(rx_seq_err), .buf_wr_en(buf_wr_en), .buf_wr_addr(buf_wr_addr),
        .buf_wr_data(buf_wr_data), .rx_busy(rx_busy), .buf_evt(buf_evt),
        .table_err(table_err), .gint(gint), .evt_count(evt_count), .cur_idx(cur_idx)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [31:0] wa [64];
    logic [7:0]  wd [64];
    int nw = 0;
    int busy_seen = 0;
    int evt_seen = 0;
    int terr_seen = 0;

    always @(posedge clk) begin
        if (rst_n) begin
            if (buf_wr_en) begin
                if (nw < 64) begin
                    wa[nw] = buf_wr_addr;
                    wd[nw] = buf_wr_data;
                end
                nw = nw + 1;
            end
            if (rx_busy) busy_seen = busy_seen + 1;
            if (buf_evt) evt_seen = evt_seen + 1;
            if (table_err) terr_seen = terr_seen + 1;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic sw_write(input int addr, input logic [15:0] val);
        @(negedge clk);
        sw_addr = AW'(addr);
        sw_wdata = val;
        sw_we = 1'b1;
        @(negedge clk);
        sw_we = 1'b0;
    endtask

    task automatic sw_read(input int addr, output logic [15:0] val);
        @(negedge clk);
        sw_addr = AW'(addr);
        #1 val = sw_rdata;
    endtask

    task automatic put_desc(input int idx, input logic [15:0] st, input logic [31:0] ptr);
        sw_write(idx * 4 + 1, 16'h0000);
        sw_write(idx * 4 + 2, ptr[31:16]);
        sw_write(idx * 4 + 3, ptr[15:0]);
        sw_write(idx * 4, st);
    endtask

    task automatic send_frame(input int n, input logic [7:0] first, input logic sq);
        nw = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_data = first + 8'(i);
            rx_last = (i == n - 1);
            rx_seq_err = sq;
        end
        @(negedge clk);
        rx_valid = 1'b0;
        rx_last = 1'b0;
        rx_seq_err = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic check_writes(input string req, input int n, input logic [31:0] base, input logic [7:0] first);
        check(req, 32'(nw), 32'(n));
        for (int i = 0; i < n && i < 64; i++) begin
            check(req, wa[i], base + 32'(i));
            check(req, 32'(wd[i]), 32'(first + 8'(i)));
        end
    endtask

    // R1
    task automatic t_reset();
        check("R1 ptr", 32'(cur_idx), 32'(cfg_base));
        check("R1 gint", 32'(gint), 32'd0);
        check("R1 count", 32'(evt_count), 32'd0);
        check("R1 no write", 32'(buf_wr_en), 32'd0);
    endtask

    // R2 R3 R4 R5 R8 R9 R6 R10
    task automatic t_ring_basic();
        logic [15:0] v;
        int e0;
        put_desc(0, 16'h9000, 32'h0000_0100);
        put_desc(1, 16'hB000, 32'h0000_0200);
        e0 = evt_seen;
        send_frame(5, 8'h10, 1'b0);
        check_writes("R2 frame0", 5, 32'h100, 8'h10);
        sw_read(1, v); check("R3 len0", 32'(v), 32'd5);
        sw_read(0, v); check("R4 stat0", 32'(v), 32'h1000);
        check("R5 advance", 32'(cur_idx), 32'd1);
        check("R8 evt0", 32'(evt_seen - e0), 32'd1);
        check("R9 below thresh", 32'(gint), 32'd0);
        check("R9 count1", 32'(evt_count), 32'd1);
        send_frame(3, 8'hA0, 1'b1);
        check_writes("R2 frame1", 3, 32'h200, 8'hA0);
        sw_read(5, v); check("R3 len1", 32'(v), 32'd3);
        sw_read(4, v); check("R4 stat1 sne", 32'(v), 32'h3800);
        check("R5 wrap", 32'(cur_idx), 32'd0);
        check("R9 count2", 32'(evt_count), 32'd2);
        check("R9 gint set", 32'(gint), 32'd1);
        // R6: descriptor 0 is now closed
        e0 = busy_seen;
        send_frame(3, 8'h55, 1'b0);
        check("R6 no writes", 32'(nw), 32'd0);
        check("R6 busy once", 32'(busy_seen - e0), 32'd1);
        check("R6 ptr held", 32'(cur_idx), 32'd0);
        sw_read(0, v); check("R6 stat kept", 32'(v), 32'h1000);
        sw_read(1, v); check("R6 len kept", 32'(v), 32'd5);
        check("R9 gint held", 32'(gint), 32'd1);
        // R10
        @(negedge clk); gint_ack = 1'b1;
        @(negedge clk); gint_ack = 1'b0;
        check("R10 gint clr", 32'(gint), 32'd0);
        check("R10 count clr", 32'(evt_count), 32'd0);
    endtask

    // R7 R8
    task automatic t_continuous();
        logic [15:0] v;
        int e0;
        put_desc(0, 16'hA200, 32'h0000_0300);
        e0 = evt_seen;
        send_frame(2, 8'h30, 1'b0);
        check_writes("R7 pass1", 2, 32'h300, 8'h30);
        sw_read(0, v); check("R7 empty kept", 32'(v), 32'hA200);
        sw_read(1, v); check("R7 len1", 32'(v), 32'd2);
        send_frame(4, 8'h40, 1'b0);
        check_writes("R7 pass2", 4, 32'h300, 8'h40);
        sw_read(1, v); check("R7 len2", 32'(v), 32'd4);
        check("R8 no evt", 32'(evt_seen - e0), 32'd0);
        check("R7 ptr", 32'(cur_idx), 32'd0);
    endtask

    // R1 R11
    task automatic t_table_end();
        logic [15:0] v;
        int e0;
        cfg_base = 3'd6;
        do_reset();
        check("R1 ptr base", 32'(cur_idx), 32'd6);
        put_desc(6, 16'h8000, 32'h0000_0400);
        put_desc(7, 16'h8000, 32'h0000_0500);
        e0 = terr_seen;
        send_frame(2, 8'h60, 1'b0);
        check("R5 step", 32'(cur_idx), 32'd7);
        check("R11 no err yet", 32'(terr_seen - e0), 32'd0);
        send_frame(1, 8'h70, 1'b0);
        check_writes("R2 single", 1, 32'h500, 8'h70);
        check("R11 err pulse", 32'(terr_seen - e0), 32'd1);
        check("R11 back to base", 32'(cur_idx), 32'd6);
        sw_read(29, v); check("R3 len single", 32'(v), 32'd1);
        sw_read(28, v); check("R4 stat plain", 32'(v), 32'h0000);
    endtask

    initial begin
        do_reset();
        t_reset();
        t_ring_basic();
        t_continuous();
        t_table_end();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule